// File: doc/BRIEF.md
# Machine Cycle Phase Sequencer

This block produces the internal timing skeleton of an 8-bit controller core in which one machine cycle is six states long and every state is split into two phases. It runs on a phase clock that ticks twice per oscillator period: the first tick of a state is phase 1 (oscillator high) and the second is phase 2 (oscillator low). From a free-running state/phase position and a per-instruction cycle index it decodes the address-latch strobe, the code-read strobes, the opcode-latch enable, the program-counter step enable and an end-of-instruction pulse.

The instruction decoder supplies a small descriptor for each instruction: its length in bytes, a code for its number of machine cycles, and a flag marking an external-data move. The descriptor is sampled once per instruction, in the phase right after the opcode has been latched. It fixes how many cycles the instruction runs, which code reads advance the program counter, and whether the second cycle goes quiet on the external bus. Two code reads are made in every machine cycle. Reads that fetch no part of the current instruction are still made, but they do not step the program counter.

Top module: `mc_sequencer`

## Requirements
- R1: While `rst_n` is low, and in the first phase after it rises, the outputs show S1 phase 1 (`st_idx`=0, `st_ph2`=0) with every strobe low. The phase after that is S1 phase 2 of a new instruction, with `op_latch` high.
- R2: `st_idx` counts 0 to 5 for states S1 to S6 and wraps back to 0. `st_ph2` is 0 in phase 1 and 1 in phase 2, and it toggles on every clock. `st_idx` advances only after phase 2.
- R3: `ale` is high exactly in S1P2, S2P1, S4P2 and S5P1 of every machine cycle, except in the case described in R8.
- R4: `code_rd` is high exactly in S1P2 and S4P2 of every machine cycle, except in the case described in R8.
- R5: `op_latch` is high only in S1P2 of the first machine cycle of an instruction.
- R6: `pc_step` is high in S1P2 of the first cycle. It is also high in S4P2 of the first cycle when the length is at least 2, and in S1P2 of the second cycle when the length is 3. `dec_len` gives the length as 1, 2 or 3 bytes, and the value 0 is taken as 1.
- R7: `dec_cyc` gives the cycle count: 0 means 1 cycle, 1 means 2 cycles, and 2 or 3 mean 4 cycles. `instr_done` is high only in S6P2 of the last cycle of an instruction.
- R8: When `dec_movx` is 1, the instruction runs 2 cycles with a length of 1, whatever `dec_len` and `dec_cyc` say. In its second cycle `ale` and `code_rd` stay low in every phase.
- R9: A length of 3 together with a one-cycle code runs as a two-cycle instruction.
- R10: The descriptor inputs are sampled only in S2P1 of an instruction's first cycle. Their values in every other phase have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Phase clock, two ticks per oscillator period |
| rst_n | input | 1 | Synchronous active-low reset |
| dec_len | input | 2 | Instruction length in bytes (0 taken as 1) |
| dec_cyc | input | 2 | Cycle count code: 0 means 1 cycle, 1 means 2 cycles, 2 or 3 mean 4 cycles |
| dec_movx | input | 1 | External-data move flag |
| st_idx | output | 3 | Current state, 0 to 5 for S1 to S6 |
| st_ph2 | output | 1 | 1 in phase 2, 0 in phase 1 |
| ale | output | 1 | Address-latch strobe |
| code_rd | output | 1 | Code-memory read strobe |
| op_latch | output | 1 | Opcode register load enable |
| pc_step | output | 1 | Program-counter increment enable |
| instr_done | output | 1 | End-of-instruction pulse in S6P2 of the last cycle |

## Verification
The hardest cases to reach from the ports are those where the sampling window of the descriptor matters. Examples are a descriptor that changes in every phase except S2P1 of the first cycle, and a reset that arrives in the middle of a four-cycle instruction. The stimulus drives the real descriptor only in that single phase and drives random values in every other phase. It also pulls reset while a four-cycle instruction is in its third cycle, and then checks that the sequence restarts cleanly. Directed descriptors cover the forced cases: a length of 3 with a one-cycle code, external moves whose other fields contradict the flag, back-to-back external moves, and the reserved codes.

// File: rtl/mcs_pkg.sv
// Shared constants, types and descriptor decoding for the machine cycle sequencer.
// Assumes six states per machine cycle and at most four machine cycles per instruction.
package mcs_pkg;
    localparam int N_STATES = 6;
    localparam int ST_W     = $clog2(N_STATES);
    localparam int CYC_W    = 2;
    localparam int LEN_W    = 2;

    typedef logic [ST_W-1:0]  state_t;
    typedef logic [CYC_W-1:0] cyc_t;
    typedef logic [LEN_W-1:0] len_t;

    localparam state_t ST_S1 = state_t'(0);
    localparam state_t ST_S2 = state_t'(1);
    localparam state_t ST_S4 = state_t'(3);
    localparam state_t ST_S5 = state_t'(4);
    localparam state_t ST_S6 = state_t'(N_STATES - 1);

    // Effective per-instruction descriptor held for the whole instruction.
    typedef struct packed {
        len_t len;
        cyc_t last;
        logic movx;
    } desc_t;

    // Map the cycle-count code to the index of the last cycle.
    function automatic cyc_t code_to_last(input logic [1:0] code);
        case (code)
            2'd0:    return cyc_t'(0);
            2'd1:    return cyc_t'(1);
            default: return cyc_t'(3);
        endcase
    endfunction
endpackage

// File: rtl/mcs_phase_ctr.sv
// Free-running state/phase position inside one machine cycle.
// Assumes clk ticks once per phase; reset parks the counter at S1 phase 1.
module mcs_phase_ctr
    import mcs_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    output state_t st,
    output logic   ph2,
    output logic   cyc_end
);
    // Toggle the phase every tick and step the state after phase 2.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st  <= ST_S1;
            ph2 <= 1'b0;
        end else begin
            ph2 <= ~ph2;
            if (ph2) begin
                st <= (st == ST_S6) ? ST_S1 : st + state_t'(1);
            end
        end
    end

    // Flag the final phase of the machine cycle.
    always_comb begin
        cyc_end = ph2 && (st == ST_S6);
    end
endmodule

// File: rtl/mcs_cycle_trk.sv
// Latches the effective instruction descriptor and tracks the cycle index within the instruction.
// Assumes the decoder output is valid in S2P1 of the first cycle; other phases are ignored.
module mcs_cycle_trk
    import mcs_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  state_t st,
    input  logic   ph2,
    input  logic   cyc_end,
    input  len_t   dec_len,
    input  logic [1:0] dec_cyc,
    input  logic   dec_movx,
    output cyc_t   cyc,
    output desc_t  desc_q
);
    desc_t desc_eff;
    logic  load;

    // Resolve the raw descriptor into effective length and last-cycle index.
    always_comb begin
        desc_eff.movx = dec_movx;
        desc_eff.len  = (dec_len == len_t'(0)) ? len_t'(1) : dec_len;
        desc_eff.last = code_to_last(dec_cyc);
        if (dec_movx) begin
            desc_eff.len  = len_t'(1);
            desc_eff.last = cyc_t'(1);
        end else if (desc_eff.len == len_t'(3) && desc_eff.last == cyc_t'(0)) begin
            desc_eff.last = cyc_t'(1);
        end
        load = !ph2 && (st == ST_S2) && (cyc == cyc_t'(0));
    end

    // Capture the descriptor once per instruction and advance the cycle index.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cyc    <= cyc_t'(0);
            desc_q <= '{len: len_t'(1), last: cyc_t'(0), movx: 1'b0};
        end else begin
            if (load) begin
                desc_q <= desc_eff;
            end
            if (cyc_end) begin
                cyc <= (cyc == desc_q.last) ? cyc_t'(0) : cyc + cyc_t'(1);
            end
        end
    end
endmodule

// File: rtl/mcs_strobe_dec.sv
// Decodes bus and pipeline strobes from the registered position and descriptor.
// Assumes a purely combinational decode, so the strobes follow the state registers directly.
module mcs_strobe_dec
    import mcs_pkg::*;
(
    input  state_t st,
    input  logic   ph2,
    input  cyc_t   cyc,
    input  desc_t  desc_q,
    output logic   ale,
    output logic   code_rd,
    output logic   op_latch,
    output logic   pc_step,
    output logic   instr_done
);
    logic first_cyc;
    logic bus_quiet;
    logic rd_slot;
    logic ale_slot;
    logic byte2_use;
    logic byte3_use;

    // Work out the strobe windows and the suppression of the second cycle of an external move.
    always_comb begin
        first_cyc  = (cyc == cyc_t'(0));
        bus_quiet  = desc_q.movx && (cyc == cyc_t'(1));
        rd_slot    = ph2 && ((st == ST_S1) || (st == ST_S4));
        ale_slot   = rd_slot || (!ph2 && ((st == ST_S2) || (st == ST_S5)));
        ale        = ale_slot && !bus_quiet;
        code_rd    = rd_slot && !bus_quiet;
        op_latch   = ph2 && (st == ST_S1) && first_cyc;
        byte2_use  = ph2 && (st == ST_S4) && first_cyc && (desc_q.len >= len_t'(2));
        byte3_use  = ph2 && (st == ST_S1) && (cyc == cyc_t'(1)) && (desc_q.len == len_t'(3));
        pc_step    = op_latch || byte2_use || byte3_use;
        instr_done = ph2 && (st == ST_S6) && (cyc == desc_q.last);
    end
endmodule

// File: rtl/mc_sequencer.sv
// Top of the machine cycle sequencer: six states of two phases per cycle, 1/2/4-cycle instructions.
// Assumes one clk tick per phase and a decoder descriptor valid in S2P1 of each first cycle.
module mc_sequencer
    import mcs_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] dec_len,
    input  logic [1:0] dec_cyc,
    input  logic       dec_movx,
    output logic [2:0] st_idx,
    output logic       st_ph2,
    output logic       ale,
    output logic       code_rd,
    output logic       op_latch,
    output logic       pc_step,
    output logic       instr_done
);
    state_t st;
    logic   ph2;
    logic   cyc_end;
    cyc_t   cyc;
    desc_t  desc_q;

    mcs_phase_ctr u_phase (
        .clk     (clk),
        .rst_n   (rst_n),
        .st      (st),
        .ph2     (ph2),
        .cyc_end (cyc_end)
    );

    mcs_cycle_trk u_cycle (
        .clk      (clk),
        .rst_n    (rst_n),
        .st       (st),
        .ph2      (ph2),
        .cyc_end  (cyc_end),
        .dec_len  (dec_len),
        .dec_cyc  (dec_cyc),
        .dec_movx (dec_movx),
        .cyc      (cyc),
        .desc_q   (desc_q)
    );

    mcs_strobe_dec u_strobe (
        .st         (st),
        .ph2        (ph2),
        .cyc        (cyc),
        .desc_q     (desc_q),
        .ale        (ale),
        .code_rd    (code_rd),
        .op_latch   (op_latch),
        .pc_step    (pc_step),
        .instr_done (instr_done)
    );

    // Present the position on the ports.
    always_comb begin
        st_idx = 3'(st);
        st_ph2 = ph2;
    end
endmodule

// File: rtl/mc_sequencer_chk.sv
// Property checker for the machine cycle sequencer, attached to the top through bind.
// Assumes synchronous active-low reset; every property is disabled while reset is low.
module mc_sequencer_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [2:0] st_idx,
    input logic       st_ph2,
    input logic       ale,
    input logic       code_rd,
    input logic       op_latch,
    input logic       pc_step,
    input logic       instr_done
);
    p_phase_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !st_ph2 |=> st_ph2);
    p_phase_fall_r2: assert property (@(posedge clk) disable iff (!rst_n)
        st_ph2 |=> !st_ph2);
    p_state_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_ph2 && st_idx != 3'd5) |=> (st_idx == $past(st_idx) + 3'd1));
    p_state_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_ph2 && st_idx == 3'd5) |=> (st_idx == 3'd0));
    p_ale_window_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ale |-> ((st_ph2 && (st_idx == 3'd0 || st_idx == 3'd3)) ||
                 (!st_ph2 && (st_idx == 3'd1 || st_idx == 3'd4))));
    p_rd_under_ale_r4: assert property (@(posedge clk) disable iff (!rst_n)
        code_rd |-> (ale && st_ph2));
    p_op_is_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
        op_latch |-> (code_rd && pc_step && st_idx == 3'd0));
    p_step_on_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
        pc_step |-> code_rd);
    p_done_slot_r7: assert property (@(posedge clk) disable iff (!rst_n)
        instr_done |-> (st_idx == 3'd5 && st_ph2));
    p_done_then_op_r7: assert property (@(posedge clk) disable iff (!rst_n)
        instr_done |=> ##1 op_latch);
endmodule

bind mc_sequencer mc_sequencer_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .st_idx     (st_idx),
    .st_ph2     (st_ph2),
    .ale        (ale),
    .code_rd    (code_rd),
    .op_latch   (op_latch),
    .pc_step    (pc_step),
    .instr_done (instr_done)
);

// File: tb/mc_sequencer_test.sv
// Self-checking bench: a phase-accurate model in bench functions, directed corner descriptors then seeded random ones.
module mc_sequencer_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] dec_len = 2'd0;
    logic [1:0] dec_cyc = 2'd0;
    logic       dec_movx = 1'b0;
    logic [2:0] st_idx;
    logic       st_ph2, ale, code_rd, op_latch, pc_step, instr_done;

    int n_checks = 0;
    int n_fail   = 0;

    // model of the position and the latched descriptor
    int m_ph = 0, m_cyc = 0, m_len = 1, m_last = 0;
    bit m_mv = 1'b0;
    int m_tag_r9 = 0;
    // instruction to drive next
    int cur_len = 1, cur_cyc = 0, n_picked = 0, n_instr = 0;
    bit cur_mv = 1'b0;

    localparam int N_DIR = 11;
    localparam int DIR_LEN [N_DIR] = '{1, 2, 3, 3, 1, 2, 0, 1, 3, 1, 2};
    localparam int DIR_CYC [N_DIR] = '{0, 0, 0, 1, 2, 3, 0, 1, 2, 1, 1};
    localparam bit DIR_MV  [N_DIR] = '{0, 0, 0, 0, 0, 0, 0, 1, 1, 1, 0};

    always #10 clk = ~clk;

    mc_sequencer uut (
        .clk(clk), .rst_n(rst_n), .dec_len(dec_len), .dec_cyc(dec_cyc), .dec_movx(dec_movx),
        .st_idx(st_idx), .st_ph2(st_ph2), .ale(ale), .code_rd(code_rd),
        .op_latch(op_latch), .pc_step(pc_step), .instr_done(instr_done)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d (phase %0d cycle %0d)", req, what, act, exp, m_ph, m_cyc);
        end
    endtask

    function automatic int f_len(input int len, input bit mv);
        if (mv) return 1;
        return (len == 0) ? 1 : len;
    endfunction

    function automatic int f_last(input int len, input int cyc, input bit mv);
        int l;
        if (mv) return 1;
        l = (cyc == 0) ? 0 : (cyc == 1) ? 1 : 3;
        if (l == 0 && len == 3) l = 1;
        return l;
    endfunction

    task automatic pick_next();
        if (n_picked < N_DIR) begin
            cur_len = DIR_LEN[n_picked];
            cur_cyc = DIR_CYC[n_picked];
            cur_mv  = DIR_MV[n_picked];
        end else begin
            cur_len = int'($urandom % 4);
            cur_cyc = int'($urandom % 4);
            cur_mv  = (($urandom % 5) == 0);
        end
        n_picked++;
    endtask

    task automatic drive_garbage();
        dec_len  = 2'($urandom);
        dec_cyc  = 2'($urandom);
        dec_movx = 1'($urandom);
    endtask

    task automatic check_outputs();
        bit quiet, ale_e, rd_e, op_e, pc_e, done_e;
        string q_tag, d_tag;
        quiet  = m_mv && m_cyc == 1;
        ale_e  = (m_ph == 1 || m_ph == 2 || m_ph == 7 || m_ph == 8) && !quiet;
        rd_e   = (m_ph == 1 || m_ph == 7) && !quiet;
        op_e   = (m_ph == 1) && (m_cyc == 0);
        pc_e   = op_e || (m_ph == 7 && m_cyc == 0 && m_len >= 2) || (m_ph == 1 && m_cyc == 1 && m_len == 3);
        done_e = (m_ph == 11) && (m_cyc == m_last);
        q_tag  = quiet ? "R8" : "R3";
        d_tag  = m_mv ? "R8/R10" : (m_tag_r9 != 0) ? "R9" : "R7/R10";
        chk("R2", "st_idx", int'(st_idx), m_ph / 2);
        chk("R2", "st_ph2", int'(st_ph2), m_ph % 2);
        chk(q_tag, "ale", int'(ale), int'(ale_e));
        chk(quiet ? "R8" : "R4", "code_rd", int'(code_rd), int'(rd_e));
        chk("R5", "op_latch", int'(op_latch), int'(op_e));
        chk("R6/R10", "pc_step", int'(pc_step), int'(pc_e));
        chk(d_tag, "instr_done", int'(instr_done), int'(done_e));
    endtask

    // One phase: check at the falling edge, drive, then follow the rising edge in the model.
    task automatic run_phase();
        bit sample;
        @(negedge clk);
        check_outputs();
        sample = (m_ph == 2) && (m_cyc == 0);
        if (sample) begin
            dec_len = 2'(cur_len); dec_cyc = 2'(cur_cyc); dec_movx = cur_mv;
        end else begin
            drive_garbage();
        end
        @(posedge clk);
        if (sample) begin
            m_len    = f_len(cur_len, cur_mv);
            m_last   = f_last(cur_len, cur_cyc, cur_mv);
            m_mv     = cur_mv;
            m_tag_r9 = (!cur_mv && cur_len == 3 && cur_cyc == 0) ? 1 : 0;
        end
        if (m_ph == 11) begin
            if (m_cyc == m_last) begin
                m_cyc = 0;
                n_instr++;
                pick_next();
            end else begin
                m_cyc++;
            end
        end
        m_ph = (m_ph + 1) % 12;
    endtask

    // R1: hold reset, check the parked outputs, release and resume the model at S1P2.
    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        drive_garbage();
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1", "st_idx", int'(st_idx), 0);
        chk("R1", "st_ph2", int'(st_ph2), 0);
        chk("R1", "ale", int'(ale), 0);
        chk("R1", "code_rd", int'(code_rd), 0);
        chk("R1", "op_latch", int'(op_latch), 0);
        chk("R1", "pc_step", int'(pc_step), 0);
        chk("R1", "instr_done", int'(instr_done), 0);
        rst_n = 1'b1;
        drive_garbage();
        @(posedge clk);
        m_ph = 1;
        m_cyc = 0;
        m_mv = 1'b0;
        pick_next();
    endtask

    initial begin
        void'($urandom(32'd20240611));
        do_reset();
        while (n_instr < N_DIR) run_phase();
        // R1: reset in the third cycle of a four-cycle instruction
        while (!(m_last == 3 && m_cyc == 2 && m_ph == 5)) run_phase();
        do_reset();
        while (n_instr < N_DIR + 70) run_phase();
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule